// File: doc/BRIEF.md
# Chained FIFO Slice Token Controller

This block joins several identical FIFO slices into one deeper first-in first-out buffer. Each slice has its own small storage and its own write and read pointers, but only one slice at a time may accept writes and only one may supply reads. That right is carried by two tokens that travel around a ring of slices. A slice passes the write token to its neighbour when it writes its last storage location. It passes the read token the same way when it reads its last location. Because the read token follows the same route as the write token, words leave the chain in the order they entered it, even when they cross slice boundaries or wrap from the last slice back to the first.

Each slice takes a first-load input. The slice with that input held low owns both tokens after reset. A token hand-off is a one-cycle pulse on the slice's expansion output, registered on the clock. The receiving slice can use the token in the same cycle the pulse arrives and keeps it from the following edge on. In chained mode the slice's half-full output is reused to carry the write hand-off pulse, so no half-full indication is produced. The top level builds the ring and forms composite active-low flags by ORing the matching flag of every slice. Write and read share one clock.

Top module: `fifo_chain_top`

## Requirements
- R1: In the cycle after reset is released, `w_token` and `r_token` both equal the one-hot bit of slice FIRST_SLICE, `empty_n` is 0, `full_n` is 1 and `rd_data` is 0.
- R2: An accepted write at local address DEPTH-1 of the write-token slice moves `w_token` to the next slice index after that clock edge. The slice after index SLICES-1 is index 0.
- R3: An accepted read at local address DEPTH-1 of the read-token slice moves `r_token` to the next slice index after that clock edge, with the same wrap from SLICES-1 to 0.
- R4: Words come out of `rd_data` in write order across all slices. The word appears after the edge that accepts the read and holds until the next accepted read.
- R5: `full_n` is 0 exactly when SLICES*DEPTH words are stored. A write requested while full is dropped and never appears at `rd_data`.
- R6: `empty_n` is 0 exactly when no word is stored. A read requested while empty is dropped and `rd_data` keeps its last value.
- R7: `almost_empty_n` is 0 exactly when every slice holds AE_OFFSET words or fewer.
- R8: `almost_full_n` is 0 exactly when every slice holds DEPTH-AF_OFFSET words or more.
- R9: A read and a write in the same cycle are both accepted when the buffer is neither empty nor full. This holds in cycles where one or both tokens move.
- R10: At every cycle exactly one bit of `w_token` and exactly one bit of `r_token` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the write and read sides |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to write |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Last word read |
| empty_n | output | 1 | Composite empty flag, low when empty |
| full_n | output | 1 | Composite full flag, low when full |
| almost_empty_n | output | 1 | Composite almost-empty flag, active low |
| almost_full_n | output | 1 | Composite almost-full flag, active low |
| w_token | output | SLICES | One-hot owner of the write token |
| r_token | output | SLICES | One-hot owner of the read token |

## Verification
The bench builds the chain with three slices of four words each, eight-bit data and both almost offsets set to one. With these values the whole ring fills in twelve writes. Every slice boundary and the wrap from the last slice back to the first are crossed many times in a short run. Per-slice occupancy often sits right at both almost thresholds. Full, empty, dropped requests and simultaneous traffic during token moves all come up within a few dozen cycles.

// File: rtl/fifo_chain_pkg.sv
package fifo_chain_pkg;
  function automatic int ring_next(input int idx, input int count);
    return (idx + 1) % count;
  endfunction

  function automatic int ring_prev(input int idx, input int count);
    return (idx + count - 1) % count;
  endfunction
endpackage

// File: rtl/chain_token.sv
module chain_token (
  input  logic clk,
  input  logic rst,
  input  logic first_n,
  input  logic pass_in,
  input  logic advance,
  output logic own,
  output logic pass_out
);
  logic own_q;

  assign own = own_q | pass_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q    <= ~first_n;
      pass_out <= 1'b0;
    end else begin
      own_q    <= own & ~advance;
      pass_out <= advance;
    end
  end

  // R2
  pass_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pass_out |=> !pass_out);

  // R3
  pass_from_owner_chk: assert property (@(posedge clk) disable iff (rst)
    advance |-> own);
endmodule

// File: rtl/chain_slice.sv
module chain_slice #(
  parameter int WIDTH      = 8,
  parameter int DEPTH      = 4,
  parameter int AE_OFFSET  = 1,
  parameter int AF_OFFSET  = 1,
  parameter bit CASCADE    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             wx_in,
  input  logic             rx_in,
  output logic             wx_hf,
  output logic             rx_out,
  output logic             w_own,
  output logic             r_own,
  output logic             rd_fire,
  output logic [WIDTH-1:0] rd_q,
  output logic             empty_n,
  output logic             full_n,
  output logic             ae_n,
  output logic             af_n
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);
  localparam logic [CW-1:0] AE_CNT    = CW'(AE_OFFSET);
  localparam logic [CW-1:0] AF_CNT    = CW'(DEPTH - AF_OFFSET);
  localparam logic [CW-1:0] HALF_CNT  = CW'(DEPTH / 2);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             wr_fire, wx_out;
  logic             w_adv, r_adv;

  assign empty_n = (cnt != '0);
  assign full_n  = (cnt != FULL_CNT);
  assign ae_n    = (cnt > AE_CNT);
  assign af_n    = (cnt < AF_CNT);

  assign wr_fire = wr_en & w_own & full_n;
  assign rd_fire = rd_en & r_own & empty_n;
  assign w_adv   = wr_fire & (wptr == LAST_ADDR);
  assign r_adv   = rd_fire & (rptr == LAST_ADDR);

  chain_token u_wtok (
    .clk(clk), .rst(rst), .first_n(first_n), .pass_in(wx_in),
    .advance(w_adv), .own(w_own), .pass_out(wx_out)
  );

  chain_token u_rtok (
    .clk(clk), .rst(rst), .first_n(first_n), .pass_in(rx_in),
    .advance(r_adv), .own(r_own), .pass_out(rx_out)
  );

  generate
    if (CASCADE) begin : g_chain
      assign wx_hf = wx_out;
    end else begin : g_alone
      assign wx_hf = ~(cnt > HALF_CNT);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_fire) begin
      rd_q <= mem[rptr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_fire) wptr <= w_adv ? '0 : wptr + 1'b1;
      if (rd_fire) rptr <= r_adv ? '0 : rptr + 1'b1;
      case ({wr_fire, rd_fire})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R5
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!full_n && !rd_fire) |=> !full_n);

  // R6
  empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && !wr_fire) |=> !empty_n);

  // R4
  rdq_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> $stable(rd_q));
endmodule

// File: rtl/fifo_chain_top.sv
module fifo_chain_top
  import fifo_chain_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int DEPTH       = 4,
  parameter int SLICES      = 3,
  parameter int FIRST_SLICE = 0,
  parameter int AE_OFFSET   = 1,
  parameter int AF_OFFSET   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic              rd_en,
  output logic [WIDTH-1:0]  rd_data,
  output logic              empty_n,
  output logic              full_n,
  output logic              almost_empty_n,
  output logic              almost_full_n,
  output logic [SLICES-1:0] w_token,
  output logic [SLICES-1:0] r_token
);
  logic [SLICES-1:0] wx, rx, fire, e_n, f_n, ae, af, sel_q;
  logic [WIDTH-1:0]  q [SLICES];
  logic [WIDTH-1:0]  mux;

  generate
    for (genvar i = 0; i < SLICES; i++) begin : g_slice
      localparam int PREV = ring_prev(i, SLICES);
      chain_slice #(
        .WIDTH(WIDTH), .DEPTH(DEPTH), .AE_OFFSET(AE_OFFSET),
        .AF_OFFSET(AF_OFFSET), .CASCADE(1'b1)
      ) u_slice (
        .clk(clk), .rst(rst),
        .first_n(i != FIRST_SLICE),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .wx_in(wx[PREV]), .rx_in(rx[PREV]),
        .wx_hf(wx[i]), .rx_out(rx[i]),
        .w_own(w_token[i]), .r_own(r_token[i]),
        .rd_fire(fire[i]), .rd_q(q[i]),
        .empty_n(e_n[i]), .full_n(f_n[i]), .ae_n(ae[i]), .af_n(af[i])
      );
    end
  endgenerate

  assign empty_n        = |e_n;
  assign full_n         = |f_n;
  assign almost_empty_n = |ae;
  assign almost_full_n  = |af;

  always_ff @(posedge clk) begin
    if (rst)        sel_q <= '0;
    else if (|fire) sel_q <= fire;
  end

  always_comb begin
    mux = '0;
    for (int i = 0; i < SLICES; i++) begin
      if (sel_q[i]) mux = mux | q[i];
    end
  end
  assign rd_data = mux;

  // R10
  wtok_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(w_token) == 1);

  // R10
  rtok_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(r_token) == 1);

  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!empty_n && rd_en) |=> $stable(rd_data));

  // R4
  single_reader_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fire));
endmodule

// File: tb/fifo_chain_top_bench.sv
module fifo_chain_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8, D = 4, N = 3, AE = 1, AF = 1;
  localparam int TOT = N * D;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic empty_n, full_n, almost_empty_n, almost_full_n;
  logic [N-1:0] w_token, r_token;

  int errors = 0, checks = 0;
  int occ = 0, gw = 0, gr = 0;
  logic [W-1:0] sb [$];
  logic [W-1:0] last_q = '0;
  logic [W-1:0] next_val = 8'h11;
  logic [15:0]  lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_chain_top #(.WIDTH(W), .DEPTH(D), .SLICES(N), .FIRST_SLICE(0),
    .AE_OFFSET(AE), .AF_OFFSET(AF)) u_fifo_chain_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .empty_n(empty_n), .full_n(full_n),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n),
    .w_token(w_token), .r_token(r_token));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int slice_occ(input int s);
    int c = 0;
    for (int k = 0; k < occ; k++) if (((gr + k) % TOT) / D == s) c++;
    return c;
  endfunction

  task automatic check_state();
    logic all_ae = 1'b1, all_af = 1'b1;
    for (int s = 0; s < N; s++) begin
      if (slice_occ(s) > AE) all_ae = 1'b0;
      if (slice_occ(s) < D - AF) all_af = 1'b0;
    end
    chk("R2 w_token", w_token, 1 << (gw / D));
    chk("R3 r_token", r_token, 1 << (gr / D));
    chk("R5 full_n", full_n, occ != TOT);
    chk("R6 empty_n", empty_n, occ != 0);
    chk("R7 almost_empty_n", almost_empty_n, !all_ae);
    chk("R8 almost_full_n", almost_full_n, !all_af);
  endtask

  // driver: called at a falling edge; returns at the next falling edge
  task automatic step(input logic wr, input logic rd);
    logic wacc, racc;
    wacc = wr && occ < TOT;
    racc = rd && occ > 0;
    wr_en = wr; rd_en = rd; wr_data = next_val;
    @(posedge clk);
    @(negedge clk);
    if (wacc) begin sb.push_back(next_val); gw = (gw + 1) % TOT; end
    if (racc) begin last_q = sb.pop_front(); gr = (gr + 1) % TOT; end
    occ = occ + int'(wacc) - int'(racc);
    next_val = next_val + 8'h07;
    // monitor compare: R4 order, R6 hold on dropped read, R9 concurrency
    if (racc) chk(wacc ? "R9 rd_data" : "R4 rd_data", rd_data, last_q);
    else if (rd) chk("R6 rd_data held", rd_data, last_q);
    else chk("R4 rd_data held", rd_data, last_q);
    check_state();
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 w_token", w_token, 3'b001);
    chk("R1 r_token", r_token, 3'b001);
    chk("R1 empty_n", empty_n, 1'b0);
    chk("R1 full_n", full_n, 1'b1);
    chk("R1 rd_data", rd_data, '0);
    // R6 read while empty
    step(1'b0, 1'b1);
    // fill the whole ring, R2 token moves through each slice
    for (int i = 0; i < TOT; i++) step(1'b1, 1'b0);
    // R5 writes while full are dropped
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    // drain, R3 token moves and wraps
    for (int i = 0; i < TOT; i++) step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    // R9 streaming with both requests, crossing boundaries and wraps
    step(1'b1, 1'b0);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1);
    // R9 read while full with write request
    for (int i = 0; i < TOT; i++) step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    // mixed pseudo-random traffic
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[1] | lfsr[5]);
    end
    for (int i = 0; i < TOT + 1; i++) step(1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule